// File: doc/BRIEF.md
# Clock-Activity Power State Controller

This block chooses the operating state of a voice codec's digital side. It runs on a free-running system clock and watches three inputs: an active-low power-down request, the serial bit clock level and the transmit frame-sync level. From them it reports one of three states: operating, power-saving or power-down. It also drives the enables that release or tri-state the serial PCM data output and the two legs of the differential analog output driver.

No register write is involved. Power-saving is inferred from the clocks themselves. A bit clock or frame sync that stops toggling and stays at either level forces power-saving once its own inactivity window runs out. The power-down request overrides everything else. Leaving power-saving needs a clean restart: both clocks must show a set number of fresh edges, and neither may be stalled. The analog circuits and any frame-sync-locked PLL are outside this block.

Both inactivity windows are parameters in system-clock cycles. The bit-clock window covers the slowest 64 kHz bit clock. The frame-sync window is a little longer than one 6 kHz frame, so any sync rate from 6 to 9 kHz keeps the block operating.

Top module: `codec_pwr_state_ctrl`

## Requirements
- R1: After reset the state code is 2'b10 (power-down) and all three output enables are low.
- R2: While `pdn_n` is low, the state becomes and stays 2'b10 within 4 system-clock cycles, whatever the bit clock and frame sync do.
- R3: A bit clock that holds either level, 1 or 0, for more than `BCLK_TIMEOUT` cycles moves an operating block to power-saving, code 2'b01.
- R4: A frame sync that holds either level, 1 or 0, for more than `FSYNC_TIMEOUT` cycles moves an operating block to power-saving, code 2'b01.
- R5: `pcm_out_en`, `aout_pos_en` and `aout_neg_en` are high only when the state code is 2'b00 (operating). They are low in power-saving and in power-down.
- R6: Edge gaps shorter than the matching timeout keep the block operating. This includes a frame sync period stretched to the slow end of the allowed range.
- R7: The state returns to operating only after both the bit clock and the frame sync have each shown at least `RESTART_EDGES` (default 2) edges since the stall, with neither currently stalled. A single edge on each is not enough.
- R8: Releasing `pdn_n` always leads to power-saving (2'b01) first, never straight to operating. With clocks stopped, the block stays in power-saving.
- R9: `aout_pos_en` and `aout_neg_en` are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Power-down request, active low, asynchronous |
| bclk_in | input | 1 | Serial bit clock level, asynchronous to clk |
| fsync_in | input | 1 | Transmit frame sync level, asynchronous to clk |
| state_code | output | 2 | 00 operating, 01 power-saving, 10 power-down |
| pcm_out_en | output | 1 | Serial PCM output enable; low means high impedance |
| aout_pos_en | output | 1 | Positive analog output driver enable |
| aout_neg_en | output | 1 | Negative analog output driver enable |

## Verification
The bench stops each clock at level 1 and at level 0. It checks the state both just inside and just past the window, so a design that catches only one stuck level, or times out early, is exposed. It stretches the frame sync period close to its window to catch a timeout that is too short. It also gives a stalled block one edge per clock to catch a restart rule that is too eager. It pulls power-down while the clocks run, keeps it low while they stop, and releases it with the clocks still stopped. A design that got the priority wrong would either leave power-down early or jump from power-down straight to operating.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic [1:0] {
        PS_OPER = 2'b00,
        PS_SAVE = 2'b01,
        PS_DOWN = 2'b10
    } pwr_state_e;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cps_activity_mon.sv
module cps_activity_mon #(
    parameter int TIMEOUT = 2500,
    parameter int STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic edge_o,
    output logic stalled_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] idle_cnt;
    } mon_t;

    mon_t mon_d, mon_q;
    logic lvl_sync;

    cps_sync #(.STAGES(STAGES), .RESET_VAL(1'b0)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (level_in),
        .dout (lvl_sync)
    );

    always_comb begin
        mon_d      = mon_q;
        mon_d.prev = lvl_sync;
        if (lvl_sync != mon_q.prev)
            mon_d.idle_cnt = '0;
        else if (mon_q.idle_cnt < LIMIT)
            mon_d.idle_cnt = mon_q.idle_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign edge_o    = lvl_sync ^ mon_q.prev;
    assign stalled_o = (mon_q.idle_cnt >= LIMIT);

    // R6: any edge restarts the inactivity window
    a_r6_edge_restarts_window: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (mon_q.idle_cnt == '0));

    // R3/R4: a stall persists until an edge arrives
    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled_o && !edge_o) |=> stalled_o);
endmodule

// File: rtl/cps_state_fsm.sv
module cps_state_fsm
    import cps_pkg::*;
#(
    parameter int RESTART_EDGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       bclk_edge,
    input  logic       bclk_stalled,
    input  logic       fsync_edge,
    input  logic       fsync_stalled,
    output pwr_state_e state_o,
    output logic       out_en_o
);
    localparam int EW = $clog2(RESTART_EDGES + 1);
    localparam logic [EW-1:0] NEED = EW'(RESTART_EDGES);

    typedef struct packed {
        pwr_state_e    st;
        logic [EW-1:0] bcnt;
        logic [EW-1:0] scnt;
        logic          en;
    } fsm_t;

    fsm_t f_d, f_q;

    function automatic logic [EW-1:0] count_edge(input logic [EW-1:0] cur,
                                                 input logic e, input logic stall);
        if (e)          return (cur < NEED) ? cur + 1'b1 : cur;
        else if (stall) return '0;
        else            return cur;
    endfunction

    always_comb begin
        f_d = f_q;
        if (!pwr_ok) begin
            f_d.st   = PS_DOWN;
            f_d.bcnt = '0;
            f_d.scnt = '0;
        end else begin
            unique case (f_q.st)
                PS_OPER: begin
                    if (bclk_stalled || fsync_stalled) begin
                        f_d.st   = PS_SAVE;
                        f_d.bcnt = '0;
                        f_d.scnt = '0;
                    end
                end
                PS_DOWN: begin
                    f_d.st   = PS_SAVE;
                    f_d.bcnt = '0;
                    f_d.scnt = '0;
                end
                default: begin
                    f_d.bcnt = count_edge(f_q.bcnt, bclk_edge, bclk_stalled);
                    f_d.scnt = count_edge(f_q.scnt, fsync_edge, fsync_stalled);
                    if (f_q.bcnt >= NEED && f_q.scnt >= NEED &&
                        !bclk_stalled && !fsync_stalled)
                        f_d.st = PS_OPER;
                end
            endcase
        end
        f_d.en = (f_d.st == PS_OPER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st   <= PS_DOWN;
            f_q.bcnt <= '0;
            f_q.scnt <= '0;
            f_q.en   <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign state_o  = f_q.st;
    assign out_en_o = f_q.en;

    // R2: power-down request wins next cycle
    a_r2_pdn_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (f_q.st == PS_DOWN));

    // R3: bit clock stall leaves operating
    a_r3_bclk_stall_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && f_q.st == PS_OPER && bclk_stalled) |=> (f_q.st == PS_SAVE));

    // R4: frame sync stall leaves operating
    a_r4_fsync_stall_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && f_q.st == PS_OPER && fsync_stalled) |=> (f_q.st == PS_SAVE));

    // R7: no restart before enough edges on both clocks
    a_r7_restart_needs_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st != PS_OPER && (f_q.bcnt < NEED || f_q.scnt < NEED)) |=> (f_q.st != PS_OPER));

    // R8: power-down never goes straight to operating
    a_r8_down_to_save: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_DOWN) |=> (f_q.st != PS_OPER));
endmodule

// File: rtl/codec_pwr_state_ctrl.sv
module codec_pwr_state_ctrl
    import cps_pkg::*;
#(
    parameter int BCLK_TIMEOUT  = 2500,
    parameter int FSYNC_TIMEOUT = 22000,
    parameter int RESTART_EDGES = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_n,
    input  logic       bclk_in,
    input  logic       fsync_in,
    output logic [1:0] state_code,
    output logic       pcm_out_en,
    output logic       aout_pos_en,
    output logic       aout_neg_en
);
    localparam int NUM_CLK = 2;

    logic [NUM_CLK-1:0] lvl_in;
    logic [NUM_CLK-1:0] edge_w;
    logic [NUM_CLK-1:0] stall_w;
    logic               pwr_ok;
    pwr_state_e         state_w;
    logic               en_w;

    assign lvl_in = {fsync_in, bclk_in};

    cps_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pdn_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pdn_n),
        .dout (pwr_ok)
    );

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_mon
        localparam int TO = (g == 0) ? BCLK_TIMEOUT : FSYNC_TIMEOUT;
        cps_activity_mon #(.TIMEOUT(TO), .STAGES(SYNC_STAGES)) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (lvl_in[g]),
            .edge_o   (edge_w[g]),
            .stalled_o(stall_w[g])
        );
    end

    cps_state_fsm #(.RESTART_EDGES(RESTART_EDGES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_ok       (pwr_ok),
        .bclk_edge    (edge_w[0]),
        .bclk_stalled (stall_w[0]),
        .fsync_edge   (edge_w[1]),
        .fsync_stalled(stall_w[1]),
        .state_o      (state_w),
        .out_en_o     (en_w)
    );

    assign state_code  = state_w;
    assign pcm_out_en  = en_w;
    assign aout_pos_en = en_w;
    assign aout_neg_en = en_w;

    // R5: drivers enabled only while operating
    a_r5_drivers_only_oper: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'b00) |-> (!pcm_out_en && !aout_pos_en && !aout_neg_en));

    // R9: differential legs agree
    a_r9_legs_match: assert property (@(posedge clk) disable iff (!rst_n)
        aout_pos_en == aout_neg_en);
endmodule

// File: tb/codec_pwr_state_ctrl_bench.sv
module codec_pwr_state_ctrl_bench;
    localparam int BT    = 40;
    localparam int ST    = 300;
    localparam int BHALF = 4;
    localparam int SHI   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_n = 1'b0;
    logic bclk = 1'b0;
    logic fsync = 1'b0;
    logic [1:0] state_code;
    logic pcm_out_en, aout_pos_en, aout_neg_en;

    logic bclk_run = 1'b0, bclk_hold = 1'b0;
    logic fs_run = 1'b0, fs_hold = 1'b0;
    int   fs_period = 200;
    int   bph = 0, sph = 0;
    int   checks = 0, errors = 0;

    always #4 clk = ~clk;

    codec_pwr_state_ctrl #(
        .BCLK_TIMEOUT(BT), .FSYNC_TIMEOUT(ST), .RESTART_EDGES(2), .SYNC_STAGES(2)
    ) u_codec_pwr_state_ctrl (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .bclk_in(bclk), .fsync_in(fsync),
        .state_code(state_code), .pcm_out_en(pcm_out_en),
        .aout_pos_en(aout_pos_en), .aout_neg_en(aout_neg_en)
    );

    always begin
        @(negedge clk);
        if (bclk_run) begin
            if (bph >= BHALF - 1) begin bclk = ~bclk; bph = 0; end
            else bph++;
        end else begin
            bclk = bclk_hold; bph = 0;
        end
        if (fs_run) begin
            fsync = (sph < SHI);
            sph = (sph >= fs_period - 1) ? 0 : sph + 1;
        end else begin
            fsync = fs_hold; sph = 0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] exp_st);
        logic exp_en;
        exp_en = (exp_st == 2'b00);
        checks++;
        if (state_code !== exp_st || pcm_out_en !== exp_en ||
            aout_pos_en !== exp_en || aout_neg_en !== exp_en) begin
            errors++;
            $display("FAIL %s: state=%b pcm=%b pos=%b neg=%b expected state=%b en=%b",
                     req, state_code, pcm_out_en, aout_pos_en, aout_neg_en, exp_st, exp_en);
        end
    endtask

    task automatic run_clocks();
        bclk_run = 1'b1; fs_run = 1'b1;
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk("R1 reset state", 2'b10);
    endtask

    task automatic t_startup();
        pdn_n = 1'b1;
        run_clocks();
        wait_cyc(20);
        chk("R8 release goes to power-saving first", 2'b01);
        wait_cyc(600);
        chk("R7 restart after edges", 2'b00);
    endtask

    task automatic t_bclk_stall(input logic lvl);
        if (lvl) @(posedge bclk); else @(negedge bclk);
        bclk_hold = lvl; bclk_run = 1'b0;
        wait_cyc(20);
        chk("R6 bclk inside window", 2'b00);
        wait_cyc(60);
        chk(lvl ? "R3 bclk stuck high" : "R3 bclk stuck low", 2'b01);
        chk("R5 drivers off in power-saving", 2'b01);
        bclk_run = 1'b1;
        wait_cyc(600);
        chk("R7 bclk recovery", 2'b00);
    endtask

    task automatic t_fsync_stall(input logic lvl);
        if (lvl) @(posedge fsync); else @(negedge fsync);
        fs_hold = lvl; fs_run = 1'b0;
        wait_cyc(150);
        chk("R6 fsync inside window", 2'b00);
        wait_cyc(250);
        chk(lvl ? "R4 fsync stuck high" : "R4 fsync stuck low", 2'b01);
        fs_run = 1'b1;
        wait_cyc(700);
        chk("R7 fsync recovery", 2'b00);
    endtask

    task automatic t_slow_sync();
        fs_period = 270;
        for (int i = 0; i < 8; i++) begin
            wait_cyc(250);
            chk("R6 slow frame sync stays operating", 2'b00);
        end
        fs_period = 200;
    endtask

    task automatic t_single_edge();
        bclk_hold = 1'b0; fs_hold = 1'b0;
        bclk_run = 1'b0; fs_run = 1'b0;
        wait_cyc(400);
        chk("R3 both stopped", 2'b01);
        bclk_hold = 1'b1; fs_hold = 1'b1;
        wait_cyc(10);
        chk("R7 one edge each is not enough", 2'b01);
        wait_cyc(100);
        chk("R7 still power-saving after single edges", 2'b01);
        run_clocks();
        wait_cyc(700);
        chk("R7 full restart", 2'b00);
    endtask

    task automatic t_pdn();
        pdn_n = 1'b0;
        wait_cyc(4);
        chk("R2 power-down with clocks running", 2'b10);
        bclk_hold = 1'b0; fs_hold = 1'b0;
        bclk_run = 1'b0; fs_run = 1'b0;
        wait_cyc(400);
        chk("R2 power-down holds with clocks stopped", 2'b10);
        pdn_n = 1'b1;
        wait_cyc(10);
        chk("R8 release with stopped clocks", 2'b01);
        wait_cyc(400);
        chk("R8 stays power-saving without clocks", 2'b01);
        run_clocks();
        wait_cyc(700);
        chk("R7 restart after power-down", 2'b00);
    endtask

    initial begin
        wait_cyc(2);
        rst_n = 1'b1;
        t_reset();
        t_startup();
        t_bclk_stall(1'b1);
        t_bclk_stall(1'b0);
        t_fsync_stall(1'b1);
        t_fsync_stall(1'b0);
        t_slow_sync();
        t_single_edge();
        t_pdn();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule